// File: doc/BRIEF.md
# Systolic Box-Constrained Multiplier Update Array

This block runs the inner solver of a fixed-bias kernel classifier trainer. A ring of `M` identical processing elements each owns one multiplier `alpha_i` and a small local memory holding row `i` of a precomputed fixed-point kernel matrix `Q`. One iteration circulates the current multipliers around the ring. At each step every element multiplies the kernel entry it needs by the multiplier it currently holds and adds the product to a running sum. After `M` steps every element has its full matrix-vector product. The element then takes a gradient step of power-of-two size, clips the result into the box `[0, C]` and stores it.

Iterations repeat until one of them leaves every multiplier unchanged, which raises a one-cycle `converged` pulse. If that never happens, an iteration limit ends the run with an `aborted` pulse. The kernel is streamed in before a run. Each element's memory stores its row rotated by the element index, so every element reads from one shared address that steps down while the multipliers move forward. A synchronous reset zeroes the multipliers. Without a reset, the next run starts from the multipliers the previous run left behind.

Top module: `svm_ring_update`

## Requirements
- R1: A synchronous reset sets every multiplier to zero and drives `busy`, `converged` and `aborted` low.
- R2: While idle, each `load_valid` cycle writes one kernel word, in row-major order: word k is `Q[k/M][k%M]`, a KW-bit two's-complement value with KF fractional bits. After `M*M` words the write position wraps to the start. Each element forms its own row's product against the rotating multipliers, so non-symmetric kernels give row-correct results.
- R3: One iteration sets every multiplier to `alpha_i - floor(g_i / 2^(KF+STEP_SHIFT))`, where `g_i = sum_j Q[i][j]*alpha_j - 2^(KF+AF) + y_i*bias`. Here `alpha` is unsigned with AF fractional bits and `bias` is signed with KF+AF fractional bits. Label bit 1 means y=+1 and label bit 0 means y=-1. All elements use the multipliers from before the iteration.
- R4: Every new multiplier is clipped into `[0, c_max]`, with no wrap-around for any input.
- R5: With `start` sampled at edge E0 while idle, `busy` is high after E0. Each iteration takes exactly M+2 cycles, so the end pulse appears n*(M+2) edges after E0, with `busy` low in that same cycle.
- R6: The run ends with `converged` high for exactly one cycle after the first iteration that leaves every multiplier unchanged.
- R7: If MAX_ITER iterations pass without convergence, `aborted` pulses for one cycle and the multipliers keep the values from the last iteration.
- R8: Without a reset between runs, a new run starts from the previous multipliers. A converged state therefore converges again in one iteration.
- R9: `start` and `load_valid` have no effect while `busy` is high. Neither the run in progress nor the kernel memory contents or write position change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| load_valid | input | 1 | Kernel word present on `load_data` |
| load_data | input | KW | Kernel word, two's complement |
| start | input | 1 | Begin a run (sampled while idle) |
| bias | input | BW | Fixed bias, two's complement |
| labels | input | M | Class label per element, 1 = positive |
| c_max | input | AW | Upper box bound for every multiplier |
| alpha_flat | output | M*AW | Multipliers, element i at bits [i*AW +: AW] |
| busy | output | 1 | Run in progress |
| converged | output | 1 | One-cycle pulse: last iteration changed nothing |
| aborted | output | 1 | One-cycle pulse: iteration limit reached |

## Verification
Errors inside the ring reach the ports in different ways. A wrong read address or a wrong rotation step gives a wrong product in one element, and that shows in `alpha_flat` at the end of the first iteration. A fault in the step or clip path shows in the same place, usually as a value outside the box or off by a power of two. A fault in the stop logic shows as a wrong pulse type or as a run whose length is not a multiple of M+2 cycles. Sweeping every label pattern across symmetric, asymmetric and oscillating kernels, with two biases and two bounds, exposes each of these within one run.

// File: rtl/svm_ring_pkg.sv
package svm_ring_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ACC  = 2'd1,
        ST_UPD  = 2'd2,
        ST_CHK  = 2'd3
    } ring_state_e;

    // distance from b forward to a on a ring of m positions
    function automatic int ring_offset(int a, int b, int m);
        return (a >= b) ? (a - b) : (a + m - b);
    endfunction

endpackage

// File: rtl/svm_ring_loader.sv
module svm_ring_loader #(
    parameter int M  = 4,
    parameter int IW = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_valid,
    input  logic          busy,
    output logic [M-1:0]  row_we,
    output logic [IW-1:0] col
);
    typedef struct packed {
        logic [IW-1:0] row;
        logic [IW-1:0] col;
    } ld_state_t;

    ld_state_t r_q, r_d;
    logic      take;

    assign take = load_valid && !busy;

    always_comb begin
        r_d = r_q;
        if (take) begin
            if (r_q.col == IW'(M - 1)) begin
                r_d.col = '0;
                r_d.row = (r_q.row == IW'(M - 1)) ? '0 : r_q.row + 1'b1;
            end else begin
                r_d.col = r_q.col + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    for (genvar gi = 0; gi < M; gi++) begin : g_sel
        assign row_we[gi] = take && (r_q.row == IW'(gi));
    end

    assign col = r_q.col;

    a_r2_one_row: assert property (@(posedge clk) disable iff (rst)
        $onehot0(row_we));
    a_r9_no_write_busy: assert property (@(posedge clk) disable iff (rst)
        busy |-> (row_we == '0));

endmodule

// File: rtl/svm_ring_ctrl.sv
module svm_ring_ctrl
    import svm_ring_pkg::*;
#(
    parameter int M        = 4,
    parameter int IW       = 2,
    parameter int MAX_ITER = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          all_eq,
    output logic          clear,
    output logic          acc_en,
    output logic          upd_en,
    output logic [IW-1:0] raddr,
    output logic          busy,
    output logic          converged,
    output logic          aborted
);
    localparam int ITW = $clog2(MAX_ITER + 1);

    typedef struct packed {
        ring_state_e    state;
        logic [IW-1:0]  step;
        logic [IW-1:0]  raddr;
        logic [ITW-1:0] iter;
        logic           conv;
        logic           abrt;
    } ctrl_state_t;

    ctrl_state_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.conv = 1'b0;
        r_d.abrt = 1'b0;
        clear    = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.state = ST_ACC;
                    r_d.step  = '0;
                    r_d.raddr = '0;
                    r_d.iter  = '0;
                    clear     = 1'b1;
                end
            end
            ST_ACC: begin
                r_d.step  = r_q.step + 1'b1;
                // shared read address walks downward while alphas move forward
                r_d.raddr = (r_q.raddr == '0) ? IW'(M - 1) : r_q.raddr - 1'b1;
                if (r_q.step == IW'(M - 1)) r_d.state = ST_UPD;
            end
            ST_UPD: begin
                r_d.state = ST_CHK;
                r_d.iter  = r_q.iter + 1'b1;
            end
            ST_CHK: begin
                if (all_eq) begin
                    r_d.state = ST_IDLE;
                    r_d.conv  = 1'b1;
                end else if (r_q.iter == ITW'(MAX_ITER)) begin
                    r_d.state = ST_IDLE;
                    r_d.abrt  = 1'b1;
                end else begin
                    r_d.state = ST_ACC;
                    r_d.step  = '0;
                    r_d.raddr = '0;
                    clear     = 1'b1;
                end
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
        end else begin
            r_q <= r_d;
        end
    end

    assign acc_en    = (r_q.state == ST_ACC);
    assign upd_en    = (r_q.state == ST_UPD);
    assign raddr     = r_q.raddr;
    assign busy      = (r_q.state != ST_IDLE);
    assign converged = r_q.conv;
    assign aborted   = r_q.abrt;

    a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
        converged |=> !converged);
    a_r7_single_abort: assert property (@(posedge clk) disable iff (rst)
        aborted |=> !aborted);
    a_r5_idle_at_end: assert property (@(posedge clk) disable iff (rst)
        (converged || aborted) |-> !busy);
    a_r5_upd_follows_acc: assert property (@(posedge clk) disable iff (rst)
        (r_q.state == ST_UPD) |-> ($past(r_q.state) == ST_ACC));

endmodule

// File: rtl/svm_ring_pe.sv
module svm_ring_pe
    import svm_ring_pkg::*;
#(
    parameter int M          = 4,
    parameter int IDX        = 0,
    parameter int IW         = 2,
    parameter int KW         = 8,
    parameter int KF         = 6,
    parameter int AW         = 8,
    parameter int AF         = 4,
    parameter int BW         = 16,
    parameter int STEP_SHIFT = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [IW-1:0]        wr_col,
    input  logic [KW-1:0]        wr_data,
    input  logic [IW-1:0]        raddr,
    input  logic                 clear,
    input  logic                 acc_en,
    input  logic                 upd_en,
    input  logic [AW-1:0]        circ_in,
    input  logic                 label,
    input  logic signed [BW-1:0] bias,
    input  logic [AW-1:0]        c_max,
    output logic [AW-1:0]        circ_out,
    output logic [AW-1:0]        alpha,
    output logic                 same
);
    localparam int PW   = KW + AW + 1;
    localparam int ACCW = PW + IW + 1;
    localparam int GW   = ((ACCW > BW) ? ACCW : BW) + 2;
    localparam int SH   = KF + STEP_SHIFT;
    localparam logic signed [GW-1:0] ONE = GW'(1) <<< (KF + AF);

    typedef struct packed {
        logic signed [ACCW-1:0] acc;
        logic [AW-1:0]          circ;
        logic [AW-1:0]          alpha;
        logic [AW-1:0]          prev;
    } pe_state_t;

    pe_state_t r_q, r_d;

    logic signed [KW-1:0] row_mem [M];
    logic signed [KW-1:0] kval;
    logic [IW-1:0]        waddr;

    // row stored rotated: column IDX lands at address 0
    assign waddr = IW'(ring_offset(int'(wr_col), IDX, M));

    always_ff @(posedge clk) begin
        if (wr_en) row_mem[waddr] <= wr_data;
    end

    assign kval = row_mem[raddr];

    logic signed [PW-1:0] prod;
    logic signed [GW-1:0] accx, bterm, grad, delta, cand, cbound;
    logic [AW-1:0]        nv;

    always_comb begin
        prod   = kval * $signed({1'b0, r_q.circ});
        accx   = {{(GW-ACCW){r_q.acc[ACCW-1]}}, r_q.acc};
        bterm  = {{(GW-BW){bias[BW-1]}}, bias};
        grad   = accx - ONE + (label ? bterm : -bterm);
        // fixed-position shift: the step is pure wiring of upper bits
        delta  = grad >>> SH;
        cand   = $signed({{(GW-AW){1'b0}}, r_q.alpha}) - delta;
        cbound = $signed({{(GW-AW){1'b0}}, c_max});
        if (cand < 0)           nv = '0;
        else if (cand > cbound) nv = c_max;
        else                    nv = cand[AW-1:0];

        r_d = r_q;
        if (clear) begin
            r_d.acc  = '0;
            r_d.circ = r_q.alpha;
        end else if (acc_en) begin
            r_d.acc  = r_q.acc + {{(ACCW-PW){prod[PW-1]}}, prod};
            r_d.circ = circ_in;
        end
        if (upd_en) begin
            r_d.prev  = r_q.alpha;
            r_d.alpha = nv;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign circ_out = r_q.circ;
    assign alpha    = r_q.alpha;
    assign same     = (r_q.alpha == r_q.prev);

    a_r4_in_box: assert property (@(posedge clk) disable iff (rst)
        ($past(upd_en) && !$past(rst)) |-> (r_q.alpha <= $past(c_max)));
    a_r9_hold_alpha: assert property (@(posedge clk) disable iff (rst)
        (!$past(upd_en) && !$past(rst)) |-> $stable(r_q.alpha));
    a_r3_no_acc_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!$past(acc_en) && !$past(clear) && !$past(rst)) |-> $stable(r_q.acc));

endmodule

// File: rtl/svm_ring_update.sv
module svm_ring_update #(
    parameter int M          = 4,
    parameter int KW         = 8,
    parameter int KF         = 6,
    parameter int AW         = 8,
    parameter int AF         = 4,
    parameter int BW         = 16,
    parameter int STEP_SHIFT = 1,
    parameter int MAX_ITER   = 64
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 load_valid,
    input  logic [KW-1:0]        load_data,
    input  logic                 start,
    input  logic signed [BW-1:0] bias,
    input  logic [M-1:0]         labels,
    input  logic [AW-1:0]        c_max,
    output logic [M*AW-1:0]      alpha_flat,
    output logic                 busy,
    output logic                 converged,
    output logic                 aborted
);
    localparam int IW = (M > 1) ? $clog2(M) : 1;

    logic [M-1:0]  row_we;
    logic [IW-1:0] wr_col;
    logic [IW-1:0] raddr;
    logic          clear, acc_en, upd_en, all_eq;
    logic [M-1:0]  same;
    logic [AW-1:0] circ  [M];
    logic [AW-1:0] alpha [M];

    svm_ring_loader #(.M(M), .IW(IW)) u_loader (
        .clk        (clk),
        .rst        (rst),
        .load_valid (load_valid),
        .busy       (busy),
        .row_we     (row_we),
        .col        (wr_col)
    );

    svm_ring_ctrl #(.M(M), .IW(IW), .MAX_ITER(MAX_ITER)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .all_eq    (all_eq),
        .clear     (clear),
        .acc_en    (acc_en),
        .upd_en    (upd_en),
        .raddr     (raddr),
        .busy      (busy),
        .converged (converged),
        .aborted   (aborted)
    );

    for (genvar gi = 0; gi < M; gi++) begin : g_pe
        localparam int PREV = (gi + M - 1) % M;
        svm_ring_pe #(
            .M(M), .IDX(gi), .IW(IW), .KW(KW), .KF(KF),
            .AW(AW), .AF(AF), .BW(BW), .STEP_SHIFT(STEP_SHIFT)
        ) u_pe (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (row_we[gi]),
            .wr_col   (wr_col),
            .wr_data  (load_data),
            .raddr    (raddr),
            .clear    (clear),
            .acc_en   (acc_en),
            .upd_en   (upd_en),
            .circ_in  (circ[PREV]),
            .label    (labels[gi]),
            .bias     (bias),
            .c_max    (c_max),
            .circ_out (circ[gi]),
            .alpha    (alpha[gi]),
            .same     (same[gi])
        );
        assign alpha_flat[gi*AW +: AW] = alpha[gi];
    end

    assign all_eq = &same;

endmodule

// File: tb/tb_svm_ring_update.sv
`timescale 1ns/1ps
module tb_svm_ring_update;
    localparam int M = 4, KW = 8, AW = 8, BW = 16, MAX_ITER = 64;
    localparam int ONE = 1024, SH = 7;

    logic clk = 0, rst = 1, load_valid = 0, start = 0;
    logic [KW-1:0]   load_data = '0;
    logic [BW-1:0]   bias = '0;
    logic [M-1:0]    labels = '0;
    logic [AW-1:0]   c_max = '0;
    logic [M*AW-1:0] alpha_flat;
    logic busy, converged, aborted;

    int tests = 0, fails = 0;
    int kq [M][M];
    int am [M];
    int n_conv = 0, n_abrt = 0;

    always #2.5 clk = ~clk;

    svm_ring_update dut (
        .clk(clk), .rst(rst), .load_valid(load_valid), .load_data(load_data),
        .start(start), .bias(bias), .labels(labels), .c_max(c_max),
        .alpha_flat(alpha_flat), .busy(busy), .converged(converged), .aborted(aborted)
    );

    task automatic check(bit ok, string req, string what, int act, int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        for (int i = 0; i < M; i++) am[i] = 0;
    endtask

    function automatic void set_kernel(int sel);
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++) begin
                if (sel == 0)      kq[i][j] = (i == j) ? 64 : 0;
                else if (sel == 1) kq[i][j] = (i == j) ? 72 : ((i * 3 + j * 5) % 7) * 6 - 14;
                else               kq[i][j] = 127;
            end
    endfunction

    // R2: row-major stream, word k = Q[k/M][k%M]
    task automatic load_kernel();
        for (int i = 0; i < M; i++)
            for (int j = 0; j < M; j++) begin
                @(negedge clk);
                load_valid = 1;
                load_data  = kq[i][j][KW-1:0];
            end
        @(negedge clk);
        load_valid = 0;
    endtask

    task automatic run_case(int lab, int b, int c, bit inject, string tag);
        int na [M];
        int exp_n, cnt, acc, g, v;
        bit exp_conv, changed, done;
        string t;
        exp_conv = 0;
        exp_n = MAX_ITER;
        for (int it = 1; it <= MAX_ITER; it++) begin
            changed = 0;
            for (int i = 0; i < M; i++) begin
                acc = 0;
                for (int j = 0; j < M; j++) acc += kq[i][j] * am[j];
                g = acc - ONE + (((lab >> i) & 1) ? b : -b);
                v = am[i] - (g >>> SH);
                if (v < 0) v = 0;
                else if (v > c) v = c;
                na[i] = v;
            end
            for (int i = 0; i < M; i++) begin
                if (na[i] != am[i]) changed = 1;
                am[i] = na[i];
            end
            if (!changed) begin
                exp_conv = 1;
                exp_n = it;
                break;
            end
        end

        @(negedge clk);
        labels = lab[M-1:0];
        bias   = b[BW-1:0];
        c_max  = c[AW-1:0];
        start  = 1;
        @(posedge clk);
        @(negedge clk);
        start = 0;
        cnt = 0;
        done = 0;
        while (!done && cnt < 2000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (cnt == 1) check(busy == 1'b1, "R5", "busy after start", busy, 1);
            if (inject && cnt == 3) begin
                start = 1; load_valid = 1; load_data = 8'h55;
            end
            if (inject && cnt == 5) begin
                start = 0; load_valid = 0;
            end
            if (converged || aborted) done = 1;
        end
        start = 0; load_valid = 0;
        if (exp_conv)
            check(converged == 1'b1 && aborted == 1'b0, "R6", "converged pulse", converged, 1);
        else
            check(aborted == 1'b1 && converged == 1'b0, "R7", "aborted pulse", aborted, 1);
        check(cnt == exp_n * (M + 2), "R5", "run length in cycles", cnt, exp_n * (M + 2));
        check(busy == 1'b0, "R5", "busy at end", busy, 0);
        for (int i = 0; i < M; i++) begin
            t = (am[i] == c || am[i] == 0) ? "R4" : tag;
            check(int'(alpha_flat[i*AW +: AW]) == am[i], t, "alpha value",
                  int'(alpha_flat[i*AW +: AW]), am[i]);
        end
        @(negedge clk);
        check(converged == 1'b0 && aborted == 1'b0, "R6", "pulse width", converged | aborted, 0);
        if (exp_conv) n_conv++; else n_abrt++;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        do_reset();
        // R1: reset state
        check(alpha_flat == '0, "R1", "alpha after reset", int'(alpha_flat), 0);
        check(busy == 0 && converged == 0 && aborted == 0, "R1", "flags after reset",
              int'({busy, converged, aborted}), 0);

        for (int sel = 0; sel < 3; sel++) begin
            set_kernel(sel);
            for (int lab = 0; lab < 16; lab++)
                for (int bi = 0; bi < 2; bi++)
                    for (int ci = 0; ci < 2; ci++) begin
                        do_reset();
                        load_kernel();
                        run_case(lab, bi ? 384 : -160, ci ? 255 : 10, 1'b0,
                                 (sel == 1) ? "R2" : "R3");
                    end
        end
        check(n_conv > 0, "R6", "some runs converge", n_conv, 1);
        check(n_abrt > 0, "R7", "some runs abort", n_abrt, 1);

        // R8: warm start without reset converges again in one iteration
        set_kernel(1);
        do_reset();
        load_kernel();
        run_case(5, 100, 255, 1'b0, "R8");
        run_case(5, 100, 255, 1'b0, "R8");

        // R9: start and load words during a run are ignored
        set_kernel(1);
        do_reset();
        load_kernel();
        run_case(9, -160, 255, 1'b1, "R9");
        do_reset();
        run_case(6, 384, 255, 1'b0, "R9");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule